// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sequences the two low-power states of a small 8-bit microcontroller core. Software writes a two-bit mode register. One bit requests idle and the other requests power-down. The block then drops one of two clock-enable outputs or both of them. The first enable feeds the CPU core. The second feeds the peripherals and the interrupt logic. While a low-power state is active, the block also overrides the external bus strobes (address-latch and program-store-enable). In idle both strobes are held high. In power-down both are driven low. In the active state the core's own strobe values pass through.

Each state has its own exit. Idle ends on the first cycle that any enabled interrupt is pending. Power-down ignores ordinary interrupt requests. It ends only when an external interrupt pin is low, enabled and set to level mode. Those pins are combined without any clock, because no clock is running in power-down. The combined level then passes through a two-flop synchronizer before the enables return. Reset also ends either state, and it can come from three places: power-on, a watchdog pulse, or an external reset pin. The external pin counts only after it has been seen high for a set number of consecutive clock periods. Any reset clears both mode bits and raises a reset request to the core, so the core restarts from its zero vector.

Top module: `lpm_sequencer`

## Requirements
- R1: A write with mode_wdata[0]=1 and mode_wdata[1]=0 in the active state enters idle. core_clk_en stays 1 in the write cycle and is 0 from the next cycle. periph_clk_en stays 1, and mode_q reads 2'b01.
- R2: A write with mode_wdata[1]=1 in the active state enters power-down. From the next cycle core_clk_en=0, periph_clk_en=0 and mode_q=2'b10.
- R3: A write with both bits set enters power-down, never idle, so mode_q=2'b10.
- R4: In idle, ale_out=1 and psen_n_out=1. In power-down both are 0. In the active state they follow core_ale and core_psen_n in the same cycle.
- R5: In idle, irq_pending=1 returns the block to the active state at the next clock edge and clears mode_q to 2'b00.
- R6: In power-down, irq_pending has no effect. A low external interrupt pin also has no effect if its enable is 0 or its level-mode flag is 0.
- R7: In power-down, a low xint_n[i] with xint_en[i]=1 and xint_level[i]=1 restores both clock enables on the third clock edge after the pin falls, because of two synchronizer flops and the state register.
- R8: ext_rst_pin, once synchronized, is a valid reset only after 24 consecutive high samples. A pulse seen high for 23 edges has no effect.
- R9: Power-on reset (rst_n low), a wdt_rst pulse or a valid external reset puts the block in the active state with mode_q=2'b00. core_rst_o is 1 during rst_n low and in the cycle after a watchdog or external reset request.
- R10: A write with both data bits 0 leaves the block active and mode_q at 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Power-on reset, asynchronous active-low |
| ext_rst_pin | input | 1 | Raw external reset pin, active high |
| wdt_rst | input | 1 | Watchdog reset request, one-cycle pulse |
| mode_wr | input | 1 | Mode register write strobe from the core |
| mode_wdata | input | 2 | Write data: bit 0 requests idle, bit 1 requests power-down |
| irq_pending | input | 1 | Some enabled interrupt is pending |
| xint_n | input | 2 | External interrupt pins, active low |
| xint_en | input | 2 | Per-pin interrupt enable |
| xint_level | input | 2 | Per-pin mode, 1 = level sensitive |
| core_ale | input | 1 | Address-latch strobe from the core |
| core_psen_n | input | 1 | Program-store strobe from the core, active low |
| mode_q | output | 2 | Current mode bits (bit 0 idle, bit 1 power-down) |
| core_clk_en | output | 1 | Clock enable for the CPU core |
| periph_clk_en | output | 1 | Clock enable for peripherals and interrupt logic |
| ale_out | output | 1 | Address-latch strobe to the pad |
| psen_n_out | output | 1 | Program-store strobe to the pad |
| core_rst_o | output | 1 | Reset request to the core |

## Verification
The hardest case to reach is the edge of the external reset filter. Its count starts only after the pin passes two synchronizer flops. The stimulus therefore holds the pin for exactly 23 and then exactly 24 clock edges while the block is in idle. It expects the idle outputs to hold through the whole shorter pulse. For the longer pulse, it expects the reset to appear exactly three edges after the 24th sample. Power-down entry is also driven with distractor inputs: a pending interrupt, an edge-mode pin and a disabled level pin, all applied together. This shows that only a qualified level wake ends the state, at a known latency.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    LPM_ACTIVE = 2'd0,
    LPM_IDLE   = 2'd1,
    LPM_PDOWN  = 2'd2
  } lpm_state_e;

  localparam int unsigned MODE_W   = 2;
  localparam int unsigned IDLE_BIT = 0;
  localparam int unsigned PD_BIT   = 1;
endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d_async;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d[g];
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/lpm_rst_qual.sv
module lpm_rst_qual #(
  parameter int unsigned QUAL_CYCLES = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  output logic rst_valid
);
  localparam int unsigned CNT_W = $clog2(QUAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUAL_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             valid_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!pin_s)               cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb valid_q = (cnt_q == CNT_MAX);
  assign rst_valid = valid_q;

  // R8: the count can only have filled while the pin was held high
  assert_valid_needs_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_valid) |-> $past(pin_s));
  assert_low_pin_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_s |=> !rst_valid);
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              irq_pending,
  input  logic              pd_wake_s,
  input  logic              ext_rst_valid,
  input  logic              wdt_rst,
  output lpm_state_e        state,
  output logic [MODE_W-1:0] mode_q,
  output logic              core_rst_o
);
  lpm_state_e        state_q, state_d;
  logic [MODE_W-1:0] mode_bits_q, mode_bits_d;
  logic              rst_req_q, rst_req_d;
  logic              sys_rst;

  always_comb sys_rst = ext_rst_valid | wdt_rst;

  // next-state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LPM_ACTIVE: begin
        if (mode_wr && mode_wdata[PD_BIT])        state_d = LPM_PDOWN;
        else if (mode_wr && mode_wdata[IDLE_BIT]) state_d = LPM_IDLE;
      end
      LPM_IDLE:  if (irq_pending) state_d = LPM_ACTIVE;
      LPM_PDOWN: if (pd_wake_s)   state_d = LPM_ACTIVE;
      default:   state_d = LPM_ACTIVE;
    endcase
    if (sys_rst) state_d = LPM_ACTIVE;
  end

  // mode register bits
  always_comb begin
    mode_bits_d = mode_bits_q;
    if (state_q == LPM_ACTIVE && mode_wr) begin
      if (mode_wdata[PD_BIT]) begin
        mode_bits_d[PD_BIT]   = 1'b1;
        mode_bits_d[IDLE_BIT] = 1'b0;
      end else if (mode_wdata[IDLE_BIT]) begin
        mode_bits_d[IDLE_BIT] = 1'b1;
      end
    end
    if (state_q == LPM_IDLE && irq_pending)  mode_bits_d[IDLE_BIT] = 1'b0;
    if (state_q == LPM_PDOWN && pd_wake_s)   mode_bits_d[PD_BIT]   = 1'b0;
    if (sys_rst) mode_bits_d = '0;
  end

  always_comb rst_req_d = sys_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= LPM_ACTIVE;
      mode_bits_q <= '0;
      rst_req_q   <= 1'b1;
    end else begin
      state_q     <= state_d;
      mode_bits_q <= mode_bits_d;
      rst_req_q   <= rst_req_d;
    end
  end

  assign state      = state_q;
  assign mode_q     = mode_bits_q;
  assign core_rst_o = rst_req_q;

  assert_pd_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LPM_ACTIVE && mode_wr && mode_wdata == 2'b11 && !sys_rst)
      |=> (state_q == LPM_PDOWN && mode_q == 2'b10));
  assert_idle_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LPM_IDLE && irq_pending) |=> (state_q == LPM_ACTIVE && mode_q == 2'b00));
  assert_pd_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LPM_PDOWN && !pd_wake_s && !sys_rst) |=> state_q == LPM_PDOWN);
  assert_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> (mode_q == 2'b00 && state_q == LPM_ACTIVE && core_rst_o));
  assert_zero_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LPM_ACTIVE && mode_wr && mode_wdata == 2'b00) |=> state_q == LPM_ACTIVE);
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int unsigned NUM_XINT    = 2,
  parameter int unsigned QUAL_CYCLES = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext_rst_pin,
  input  logic                wdt_rst,
  input  logic                mode_wr,
  input  logic [MODE_W-1:0]   mode_wdata,
  input  logic                irq_pending,
  input  logic [NUM_XINT-1:0] xint_n,
  input  logic [NUM_XINT-1:0] xint_en,
  input  logic [NUM_XINT-1:0] xint_level,
  input  logic                core_ale,
  input  logic                core_psen_n,
  output logic [MODE_W-1:0]   mode_q,
  output logic                core_clk_en,
  output logic                periph_clk_en,
  output logic                ale_out,
  output logic                psen_n_out,
  output logic                core_rst_o
);
  logic [NUM_XINT-1:0] wake_lvl;
  logic                wake_any;
  logic                wake_s;
  logic                rst_pin_s;
  logic                ext_rst_valid;
  lpm_state_e          state;

  // level wake qualification, combined without any clock
  generate
    for (genvar i = 0; i < NUM_XINT; i++) begin : g_wake
      assign wake_lvl[i] = ~xint_n[i] & xint_en[i] & xint_level[i];
    end
  endgenerate
  assign wake_any = |wake_lvl;

  lpm_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) i_wake_sync (
    .clk(clk), .rst_n(rst_n), .d_async(wake_any), .q_sync(wake_s)
  );

  lpm_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_async(ext_rst_pin), .q_sync(rst_pin_s)
  );

  lpm_rst_qual #(.QUAL_CYCLES(QUAL_CYCLES)) i_rst_qual (
    .clk(clk), .rst_n(rst_n), .pin_s(rst_pin_s), .rst_valid(ext_rst_valid)
  );

  lpm_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .irq_pending(irq_pending), .pd_wake_s(wake_s), .ext_rst_valid(ext_rst_valid),
    .wdt_rst(wdt_rst), .state(state), .mode_q(mode_q), .core_rst_o(core_rst_o)
  );

  // clock enables and strobe override, all from the registered state
  always_comb begin
    core_clk_en   = (state == LPM_ACTIVE);
    periph_clk_en = (state != LPM_PDOWN);
    unique case (state)
      LPM_IDLE:  begin ale_out = 1'b1; psen_n_out = 1'b1; end
      LPM_PDOWN: begin ale_out = 1'b0; psen_n_out = 1'b0; end
      default:   begin ale_out = core_ale; psen_n_out = core_psen_n; end
    endcase
  end

  assert_idle_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_clk_en && periph_clk_en) |-> (ale_out && psen_n_out));
  assert_pd_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_clk_en |-> (!ale_out && !psen_n_out && !core_clk_en));
  assert_write_completes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && mode_wr && mode_wdata == 2'b01 && !wdt_rst && !ext_rst_valid)
      |=> (!core_clk_en && periph_clk_en && mode_q == 2'b01));
  assert_pd_enters_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && mode_wr && mode_wdata[PD_BIT] && !wdt_rst && !ext_rst_valid)
      |=> (!core_clk_en && !periph_clk_en));
  assert_pd_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!periph_clk_en && wake_s) |=> (core_clk_en && periph_clk_en));
endmodule

// File: tb/test_lpm_sequencer.sv
module test_lpm_sequencer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_rst_pin = 1'b0, wdt_rst = 1'b0, mode_wr = 1'b0, irq_pending = 1'b0;
  logic [1:0] mode_wdata = 2'b00;
  logic [1:0] xint_n = 2'b11, xint_en = 2'b00, xint_level = 2'b00;
  logic       core_ale = 1'b0, core_psen_n = 1'b1;
  logic [1:0] mode_q;
  logic       core_clk_en, periph_clk_en, ale_out, psen_n_out, core_rst_o;

  lpm_sequencer i_lpm_sequencer (
    .clk(clk), .rst_n(rst_n), .ext_rst_pin(ext_rst_pin), .wdt_rst(wdt_rst),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata), .irq_pending(irq_pending),
    .xint_n(xint_n), .xint_en(xint_en), .xint_level(xint_level),
    .core_ale(core_ale), .core_psen_n(core_psen_n), .mode_q(mode_q),
    .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en), .ale_out(ale_out),
    .psen_n_out(psen_n_out), .core_rst_o(core_rst_o)
  );

  always #5 clk = ~clk;

  // observed vector {core_clk_en, periph_clk_en, ale_out, psen_n_out, core_rst_o, mode_q}
  localparam logic [6:0] V_ACT  = 7'b1101000;
  localparam logic [6:0] V_RST  = 7'b1101100;
  localparam logic [6:0] V_IDLE = 7'b0111001;
  localparam logic [6:0] V_PD   = 7'b0000010;

  typedef struct { int tgt; logic [6:0] v; string req; } exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, fails = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int d, input logic [6:0] v, input string req);
    exp_t e;
    e.tgt = cyc + d; e.v = v; e.req = req;
    q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic write_mode(input logic [1:0] d);
    mode_wr = 1'b1; mode_wdata = d;
    step(1);
    mode_wr = 1'b0; mode_wdata = 2'b00;
  endtask

  // monitor: compare every expectation due in this cycle
  always @(negedge clk) begin
    logic [6:0] obs;
    obs = {core_clk_en, periph_clk_en, ale_out, psen_n_out, core_rst_o, mode_q};
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].tgt == cyc) begin
        checks++;
        if (obs !== q[i].v) begin
          fails++;
          $display("FAIL %s cycle %0d: actual %b expected %b", q[i].req, cyc, obs, q[i].v);
        end
        q.delete(i);
      end
    end
  end

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    expect_at(0, V_RST, "R9 power-on reset state");
    expect_at(1, V_ACT, "R9 active after reset");
    step(3);

    core_ale = 1'b1;
    expect_at(0, 7'b1111000, "R4 active strobe passthrough");
    step(1);
    core_ale = 1'b0;

    // R1 idle entry, writing cycle still active
    expect_at(0, V_ACT, "R1 write cycle completes");
    expect_at(1, V_IDLE, "R1 idle entry / R4 idle strobes");
    write_mode(2'b01);
    step(1);

    // R5 idle wake
    irq_pending = 1'b1;
    expect_at(0, V_IDLE, "R5 before wake");
    expect_at(1, V_ACT, "R5 wake on interrupt");
    step(1);
    irq_pending = 1'b0;
    step(2);

    // R10 zero write
    expect_at(1, V_ACT, "R10 zero write ignored");
    write_mode(2'b00);
    step(1);

    // R2 power-down, R6 distractors
    expect_at(1, V_PD, "R2 power-down entry / R4 low strobes");
    write_mode(2'b10);
    irq_pending = 1'b1;
    xint_n = 2'b00; xint_en = 2'b01; xint_level = 2'b10;
    expect_at(4, V_PD, "R6 irq, edge-mode and disabled pins ignored");
    step(5);
    irq_pending = 1'b0;

    // R7 qualified level wake, three edges latency
    xint_n = 2'b10; xint_en = 2'b01; xint_level = 2'b01;
    expect_at(2, V_PD, "R7 still down after two edges");
    expect_at(3, V_ACT, "R7 wake on level interrupt");
    step(3);
    xint_n = 2'b11; xint_en = 2'b00; xint_level = 2'b00;
    step(3);

    // R3 both bits -> power-down
    expect_at(1, V_PD, "R3 power-down priority");
    write_mode(2'b11);
    xint_n = 2'b01; xint_en = 2'b10; xint_level = 2'b10;
    expect_at(3, V_ACT, "R7 wake on second pin");
    step(3);
    xint_n = 2'b11; xint_en = 2'b00; xint_level = 2'b00;
    step(3);

    // R9 watchdog reset from idle
    write_mode(2'b01);
    wdt_rst = 1'b1;
    expect_at(0, V_IDLE, "R9 idle before watchdog");
    expect_at(1, V_RST, "R9 watchdog reset");
    step(1);
    wdt_rst = 1'b0;
    expect_at(1, V_ACT, "R9 reset request ends");
    step(2);

    // R8 23-edge pulse is ignored
    write_mode(2'b01);
    ext_rst_pin = 1'b1;
    step(23);
    ext_rst_pin = 1'b0;
    expect_at(5, V_IDLE, "R8 short reset pulse ignored");
    step(6);

    // R8 24-edge pulse resets
    ext_rst_pin = 1'b1;
    expect_at(26, V_IDLE, "R8 no early reset");
    expect_at(27, V_RST, "R8 qualified external reset");
    expect_at(28, V_ACT, "R9 active after external reset");
    step(24);
    ext_rst_pin = 1'b0;
    step(8);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end
endmodule